// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Hi/Lo Result Pair

This block performs integer multiplication and division for a 32-bit core. It keeps its results in a private register pair, Hi and Lo. Hi and Lo are separate from the core's general register file. The core issues a command with two operands. The unit then works through the operation one bit per clock and raises a single-cycle completion pulse when the pair has been updated.

The core reads Hi or Lo through a read port. A read that arrives while an operation is still running is answered with a stall, which lasts until the new result has been written. Multiply splits the 64-bit product across the pair, with the upper half in Hi. Divide places the quotient in Lo and the remainder in Hi. Dividing by zero never traps: it writes a fixed pattern to the pair.

The operand width is a parameter (default 32). An operation takes one cycle per operand bit, plus one cycle for the final sign correction.

Top module: `muldiv_unit`

## Requirements
- R1: Command code 2'b00 (signed multiply) writes the upper half of the two's-complement product of `a_i` and `b_i` into Hi and the lower half into Lo.
- R2: Command code 2'b01 (unsigned multiply) treats both operands as natural numbers. It writes the upper product half into Hi and the lower half into Lo.
- R3: Command code 2'b11 (unsigned divide) writes the quotient `a_i / b_i` into Lo and the remainder into Hi.
- R4: Command code 2'b10 (signed divide) rounds the quotient toward zero, and the remainder takes the sign of the dividend. The most negative dividend divided by -1 yields Lo = 0x80000000 and Hi = 0.
- R5: A divide (signed or unsigned) whose `b_i` is zero completes normally. It leaves Lo all ones and Hi equal to the unmodified `a_i`.
- R6: A start accepted at a rising edge raises `busy_o` after that edge. `done_o` pulses for exactly one cycle XLEN+1 edges later, in the same cycle in which `busy_o` falls.
- R7: `rd_data_o` shows Hi when `rd_sel_i` is 1 and Lo when it is 0, with no clock delay.
- R8: `stall_o` is high exactly when `rd_req_i` is high while `busy_o` is high.
- R9: Hi and Lo hold their previous values during an operation and change only at the edge that raises `done_o`.
- R10: A `start_i` seen while busy is ignored. `busy_o` stays high, the running operation finishes with its own result and timing, and no extra completion occurs.
- R11: After reset, Hi and Lo are zero and `busy_o`, `done_o` and `stall_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation when idle |
| op_i | input | 2 | Command: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| a_i | input | XLEN | Multiplicand or dividend |
| b_i | input | XLEN | Multiplier or divisor |
| rd_req_i | input | 1 | Core wants to read Hi or Lo |
| rd_sel_i | input | 1 | Read select: 1 = Hi, 0 = Lo |
| rd_data_o | output | XLEN | Selected result register |
| stall_o | output | 1 | Read must wait for the running operation |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when Hi/Lo are updated |

## Verification
Two events can land on the same cycle:
- A core read can coincide with an operation in flight. The bench holds `rd_req_i` high from the middle of an operation until completion. It checks that the stall is present and that Lo still shows the older result. It then checks that the stall has gone in the cycle where `done_o` rises and the new value appears.
- A fresh start can coincide with a running computation. A second start is pulsed in the middle of an operation. The bench judges it by the unchanged latency, the unchanged result popped from the scoreboard, and the absence of a second completion.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

   typedef enum logic [1:0] {
      OP_MULS = 2'b00,
      OP_MULU = 2'b01,
      OP_DIVS = 2'b10,
      OP_DIVU = 2'b11
   } mdu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_ITER = 2'b01,
      ST_FIX  = 2'b10
   } mdu_state_e;

   function automatic logic op_is_div(input logic [1:0] op);
      return op[1];
   endfunction

   function automatic logic op_is_signed(input logic [1:0] op);
      return ~op[0];
   endfunction

endpackage

// File: rtl/mdu_sign_prep.sv
// Converts both operands to magnitudes and records which were negative.
module mdu_sign_prep #(
   parameter int XLEN = 32
) (
   input  logic            is_signed,
   input  logic [XLEN-1:0] a_raw,
   input  logic [XLEN-1:0] b_raw,
   output logic [XLEN-1:0] a_mag,
   output logic [XLEN-1:0] b_mag,
   output logic            a_neg,
   output logic            b_neg
);
   localparam int NOPS = 2;
   localparam logic [XLEN-1:0] ONE_X = XLEN'(1);

   logic [XLEN-1:0] raw [NOPS];
   logic [XLEN-1:0] mag [NOPS];
   logic            neg [NOPS];

   assign raw[0] = a_raw;
   assign raw[1] = b_raw;

   for (genvar g = 0; g < NOPS; g++) begin : g_opnd
      assign neg[g] = is_signed & raw[g][XLEN-1];
      assign mag[g] = neg[g] ? (~raw[g] + ONE_X) : raw[g];
   end

   assign a_mag = mag[0];
   assign b_mag = mag[1];
   assign a_neg = neg[0];
   assign b_neg = neg[1];
endmodule

// File: rtl/mdu_iter_step.sv
// One iteration of either the shift-add multiplier or the restoring divider.
// Multiply: acc = {partial high, remaining multiplier}; shifts right.
// Divide:   acc = {partial remainder, dividend/quotient}; shifts left.
module mdu_iter_step #(
   parameter int XLEN = 32
) (
   input  logic              is_div,
   input  logic [2*XLEN-1:0] acc,
   input  logic [XLEN-1:0]   mcand,
   output logic [2*XLEN-1:0] acc_next
);
   localparam int AW = 2 * XLEN;

   logic [XLEN:0]   mul_sum;
   logic [AW-1:0]   mul_next;
   logic [XLEN:0]   div_shift;
   logic [XLEN:0]   div_diff;
   logic [AW-1:0]   div_next;

   always_comb begin
      mul_sum  = {1'b0, acc[AW-1:XLEN]} + (acc[0] ? {1'b0, mcand} : '0);
      mul_next = {mul_sum, acc[XLEN-1:1]};
   end

   always_comb begin
      div_shift = {acc[AW-1:XLEN], acc[XLEN-1]};
      div_diff  = div_shift - {1'b0, mcand};
      if (!div_diff[XLEN])
         div_next = {div_diff[XLEN-1:0], acc[XLEN-2:0], 1'b1};
      else
         div_next = {div_shift[XLEN-1:0], acc[XLEN-2:0], 1'b0};
   end

   assign acc_next = is_div ? div_next : mul_next;

   // R3: restoring keeps the partial remainder below the divisor
   always_comb begin
      if (is_div && mcand != '0) begin
         rem_bound_chk: assert (div_next[AW-1:XLEN] < mcand || acc[AW-1:XLEN] >= mcand)
            else $error("partial remainder escaped divisor bound");
      end
   end
endmodule

// File: rtl/mdu_fix.sv
// Final sign correction and divide-by-zero result.
module mdu_fix #(
   parameter int XLEN = 32
) (
   input  logic              is_div,
   input  logic              neg_main,
   input  logic              neg_rem,
   input  logic              div_zero,
   input  logic [XLEN-1:0]   dividend_raw,
   input  logic [2*XLEN-1:0] acc,
   output logic [XLEN-1:0]   hi,
   output logic [XLEN-1:0]   lo
);
   localparam int AW = 2 * XLEN;
   localparam logic [AW-1:0]   ONE_W = AW'(1);
   localparam logic [XLEN-1:0] ONE_X = XLEN'(1);

   logic [AW-1:0]   prod;
   logic [XLEN-1:0] quot;
   logic [XLEN-1:0] rem;

   always_comb begin
      prod = neg_main ? (~acc + ONE_W) : acc;
      quot = neg_main ? (~acc[XLEN-1:0] + ONE_X) : acc[XLEN-1:0];
      rem  = neg_rem  ? (~acc[AW-1:XLEN] + ONE_X) : acc[AW-1:XLEN];
      if (!is_div) begin
         hi = prod[AW-1:XLEN];
         lo = prod[XLEN-1:0];
      end else if (div_zero) begin
         hi = dividend_raw;
         lo = '1;
      end else begin
         hi = rem;
         lo = quot;
      end
   end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [1:0]      op_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic            rd_req_i,
   input  logic            rd_sel_i,
   output logic [XLEN-1:0] rd_data_o,
   output logic            stall_o,
   output logic            busy_o,
   output logic            done_o
);
   import mdu_pkg::*;

   localparam int CW = $clog2(XLEN);
   localparam int AW = 2 * XLEN;
   localparam logic [CW-1:0] LAST_STEP = CW'(XLEN - 1);
   localparam logic [CW-1:0] ONE_C = CW'(1);

   if (XLEN < 4 || (XLEN % 2) != 0) begin : g_bad_xlen
      $error("muldiv_unit: XLEN must be even and at least 4");
   end

   mdu_state_e      state_q;
   logic [CW-1:0]   step_q;
   logic [AW-1:0]   acc_q;
   logic [AW-1:0]   acc_step;
   logic [XLEN-1:0] mcand_q;
   logic [XLEN-1:0] dividend_q;
   logic            is_div_q;
   logic            neg_main_q;
   logic            neg_rem_q;
   logic            div_zero_q;
   logic [XLEN-1:0] hi_q;
   logic [XLEN-1:0] lo_q;
   logic            done_q;

   logic [XLEN-1:0] a_mag;
   logic [XLEN-1:0] b_mag;
   logic            a_neg;
   logic            b_neg;
   logic [XLEN-1:0] fix_hi;
   logic [XLEN-1:0] fix_lo;
   logic            cmd_div;

   assign cmd_div = op_is_div(op_i);

   mdu_sign_prep #(.XLEN(XLEN)) u_prep (
      .is_signed (op_is_signed(op_i)),
      .a_raw     (a_i),
      .b_raw     (b_i),
      .a_mag     (a_mag),
      .b_mag     (b_mag),
      .a_neg     (a_neg),
      .b_neg     (b_neg)
   );

   mdu_iter_step #(.XLEN(XLEN)) u_step (
      .is_div   (is_div_q),
      .acc      (acc_q),
      .mcand    (mcand_q),
      .acc_next (acc_step)
   );

   mdu_fix #(.XLEN(XLEN)) u_fix (
      .is_div       (is_div_q),
      .neg_main     (neg_main_q),
      .neg_rem      (neg_rem_q),
      .div_zero     (div_zero_q),
      .dividend_raw (dividend_q),
      .acc          (acc_q),
      .hi           (fix_hi),
      .lo           (fix_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         step_q     <= '0;
         acc_q      <= '0;
         mcand_q    <= '0;
         dividend_q <= '0;
         is_div_q   <= 1'b0;
         neg_main_q <= 1'b0;
         neg_rem_q  <= 1'b0;
         div_zero_q <= 1'b0;
         hi_q       <= '0;
         lo_q       <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  acc_q      <= {{XLEN{1'b0}}, (cmd_div ? a_mag : b_mag)};
                  mcand_q    <= cmd_div ? b_mag : a_mag;
                  dividend_q <= a_i;
                  is_div_q   <= cmd_div;
                  neg_main_q <= a_neg ^ b_neg;
                  neg_rem_q  <= a_neg;
                  div_zero_q <= cmd_div && (b_i == '0);
                  step_q     <= '0;
                  state_q    <= ST_ITER;
               end
            end
            ST_ITER: begin
               acc_q  <= acc_step;
               step_q <= step_q + ONE_C;
               if (step_q == LAST_STEP) state_q <= ST_FIX;
            end
            ST_FIX: begin
               hi_q    <= fix_hi;
               lo_q    <= fix_lo;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;
   assign stall_o   = rd_req_i & busy_o;
   assign rd_data_o = rd_sel_i ? hi_q : lo_q;

   // R9
   hilo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ITER) |=> ($stable(hi_q) && $stable(lo_q)));

   // R6
   done_after_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FIX) |=> (done_o && !busy_o));

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ITER && start_i) |=> busy_o);

   // R6
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_ITER) |=> (state_q != ST_ITER || step_q == '0));

   // R8
   stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !stall_o);
endmodule

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 32;
   localparam int LAT  = XLEN + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [1:0]      op_i = 2'b00;
   logic [XLEN-1:0] a_i = '0;
   logic [XLEN-1:0] b_i = '0;
   logic            rd_req_i = 1'b0;
   logic            rd_sel_i = 1'b0;
   logic [XLEN-1:0] rd_data_o;
   logic            stall_o;
   logic            busy_o;
   logic            done_o;

   muldiv_unit #(.XLEN(XLEN)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .rd_req_i(rd_req_i), .rd_sel_i(rd_sel_i),
      .rd_data_o(rd_data_o), .stall_o(stall_o), .busy_o(busy_o), .done_o(done_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct {
      logic [31:0] hi;
      logic [31:0] lo;
      int          req;
   } exp_t;

   exp_t scb[$];
   int   checks = 0;
   int   errors = 0;
   bit   reported = 0;
   logic [31:0] cur_lo = '0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
      end
      $finish;
   endtask

   function automatic exp_t model(input logic [1:0] op, input logic [31:0] a,
                                  input logic [31:0] b, input int req);
      exp_t   e;
      longint sa, sbv, q, r;
      logic [63:0] p;
      e.req = req;
      sa  = longint'($signed(a));
      sbv = longint'($signed(b));
      case (op)
         2'b00: begin p = 64'(sa * sbv); e.hi = p[63:32]; e.lo = p[31:0]; end
         2'b01: begin p = {32'b0, a} * {32'b0, b}; e.hi = p[63:32]; e.lo = p[31:0]; end
         default: begin
            if (b == 0) begin
               e.hi = a; e.lo = '1;
            end else if (op == 2'b11) begin
               e.lo = a / b; e.hi = a % b;
            end else begin
               q = sa / sbv; r = sa % sbv;
               e.lo = q[31:0]; e.hi = r[31:0];
            end
         end
      endcase
      return e;
   endfunction

   // Driver: issues one operation, checks timing, optional mid-run pokes.
   task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                         input int req, input bit poke_start, input bit poke_read);
      exp_t e;
      int   k;
      @(negedge clk);
      while (busy_o) @(negedge clk);
      start_i = 1'b1; op_i = op; a_i = a; b_i = b;
      e = model(op, a, b, req);
      scb.push_back(e);
      @(negedge clk);
      start_i = 1'b0;
      // R6: busy right after the accepting edge
      check(busy_o === 1'b1 && done_o === 1'b0, "R6", "busy after start", {62'b0, busy_o, done_o}, 64'h2);
      k = 0;
      while (done_o !== 1'b1 && k <= LAT + 4) begin
         if (poke_start && k == 3) begin
            start_i = 1'b1; op_i = 2'b01; a_i = 32'd5; b_i = 32'd7;
         end
         if (poke_start && k == 4) begin
            start_i = 1'b0;
            // R10: second start did not drop busy
            check(busy_o === 1'b1, "R10", "busy after ignored start", {63'b0, busy_o}, 64'h1);
         end
         if (poke_read && k == 5) begin
            rd_req_i = 1'b1;
            #1;
            // R8: read while busy stalls
            check(stall_o === 1'b1, "R8", "stall while busy", {63'b0, stall_o}, 64'h1);
            // R9: Lo still holds the previous result
            check(rd_data_o === cur_lo, "R9", "Lo held during run", {32'b0, rd_data_o}, {32'b0, cur_lo});
         end
         @(negedge clk);
         k++;
      end
      // R6: completion latency and busy release
      check(k == LAT && busy_o === 1'b0, "R6", "done latency", 64'(k), 64'(LAT));
      if (poke_read) begin
         // R8: stall released in the completion cycle
         check(stall_o === 1'b0, "R8", "stall at done", {63'b0, stall_o}, 64'h0);
         rd_req_i = 1'b0;
      end
      cur_lo = e.lo;
   endtask

   // Monitor: pops expected items on each completion and reads both halves (R7).
   task automatic monitor();
      exp_t e;
      forever begin
         @(negedge clk);
         if (done_o === 1'b1) begin
            if (scb.size() == 0) begin
               check(1'b0, "R10", "completion with empty scoreboard", 64'h1, 64'h0);
            end else begin
               e = scb.pop_front();
               rd_sel_i = 1'b1;
               #1;
               check(rd_data_o === e.hi, $sformatf("R%0d", e.req), "Hi", {32'b0, rd_data_o}, {32'b0, e.hi});
               rd_sel_i = 1'b0;
               #1;
               check(rd_data_o === e.lo, $sformatf("R%0d", e.req), "Lo", {32'b0, rd_data_o}, {32'b0, e.lo});
            end
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      rd_req_i = 1'b1;
      #(CLK_PERIOD * 2 + 1);
      // R11: reset state, and no stall on a read while idle (R8)
      check(busy_o === 1'b0 && done_o === 1'b0 && stall_o === 1'b0, "R11", "reset flags",
            {61'b0, busy_o, done_o, stall_o}, 64'h0);
      rst_n = 1'b1;
      rd_req_i = 1'b0;
      @(negedge clk);
      rd_sel_i = 1'b1;
      #1;
      check(rd_data_o === '0, "R11", "Hi after reset", {32'b0, rd_data_o}, 64'h0);
      rd_sel_i = 1'b0;
      #1;
      check(rd_data_o === '0, "R11", "Lo after reset", {32'b0, rd_data_o}, 64'h0);
      fork
         monitor();
      join_none

      // R1: signed multiply
      run_op(2'b00, 32'hFFFF_FFFD, 32'd7, 1, 0, 0);
      run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 1, 0, 1);
      // R2: unsigned multiply
      run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, 1, 0);
      run_op(2'b01, 32'h1234_5678, 32'h0000_0010, 2, 0, 0);
      // R3: unsigned divide
      run_op(2'b11, 32'hFFFF_FFFF, 32'd10, 3, 0, 1);
      run_op(2'b11, 32'd5, 32'd9, 3, 0, 0);
      // R4: signed divide, truncation and remainder sign
      run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 4, 0, 0);
      run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 4, 1, 0);
      run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 4, 0, 0);
      // R5: divide by zero, both variants
      run_op(2'b10, 32'hFFFF_FF00, 32'd0, 5, 0, 0);
      run_op(2'b11, 32'h0000_1234, 32'd0, 5, 0, 1);
      // mixed patterns
      for (int i = 1; i <= 8; i++) begin
         logic [31:0] a, b;
         logic [1:0]  op;
         a  = 32'h9E37_79B9 * i;
         b  = (32'h85EB_CA6B * i) >> (i % 5);
         op = 2'(i % 4);
         run_op(op, a, b, (op == 2'b00) ? 1 : (op == 2'b01) ? 2 : (op == 2'b10) ? 4 : 3, i == 3, i == 6);
      end
      repeat (4) @(negedge clk);
      check(scb.size() == 0, "R6", "all results delivered", 64'(scb.size()), 64'h0);
      report();
   end
endmodule